// File: doc/BRIEF.md
# Shift, Rotate and Bit-Transfer Unit

This is an 8-bit unit that works on a single operand. It covers these operations:

- left and right logical shifts;
- left and right rotates that pass through the carry flag;
- a right shift that keeps the sign bit;
- an exchange of the two nibbles;
- two single-bit moves between the operand and the T flag.

The datapath takes the operand byte, an operation code, a bit index and the current C and T flags. It returns the result byte. It also returns candidate values for Z, C, N, V, S and T, and each of these has its own write-enable.

The inputs are captured on every rising clock edge, and the result and flags appear one cycle later. A flag's write-enable tells the surrounding core whether to commit that flag. The unit does not access a register file and does not chain multi-byte shifts.

Top module: `bit_shift_unit`

## Requirements
- R1: Operation code 1 (shift left) returns the operand moved up one bit with 0 in bit 0, and C takes the old bit 7.
- R2: Operation code 2 (shift right) returns the operand moved down one bit with 0 in bit 7, and C takes the old bit 0.
- R3: Operation codes 3 (rotate left) and 4 (rotate right) work as follows. Rotate left puts the incoming C into bit 0 and sends the old bit 7 to C. Rotate right puts the incoming C into bit 7 and sends the old bit 0 to C.
- R4: Operation code 5 (sign-keeping right shift) moves bits 7..1 into 6..0, leaves bit 7 unchanged, and sends the old bit 0 to C.
- R5: The flags for codes 1 to 5 are set as follows.
  - N is result bit 7.
  - Z is 1 exactly when the result is zero.
  - V is N xor the new C.
  - S is N xor V.
  - The write-enables for Z, C, N, V and S are high, and the T write-enable is low.
  - Enables are reported in the order {Z,C,N,V,S,T}.
- R6: Operation code 6 returns the operand with its high and low nibbles exchanged, and every write-enable is low.
- R7: Operation code 7 copies operand bit number bit_idx to T, raises only the T write-enable, and passes the operand through unchanged.
- R8: Operation code 8 returns the operand with bit number bit_idx replaced by the incoming T, and every write-enable is low.
- R9: Operation code 0 and codes 9 to 15 pass the operand through unchanged, with every write-enable low.
- R10: A flag output whose write-enable is low reads 0.
- R11: Results appear on the clock edge after the inputs are captured. Back-to-back operations each produce their own result. While rst_n is low, every output is 0.

Operation codes are given in decimal on the 4-bit op_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_sel | input | 4 | Operation code |
| operand | input | 8 | Source byte |
| bit_idx | input | 3 | Bit position for codes 7 and 8 |
| c_in | input | 1 | Current carry flag |
| t_in | input | 1 | Current T flag |
| result | output | 8 | Result byte |
| z_out | output | 1 | Zero flag candidate |
| c_out | output | 1 | Carry flag candidate |
| n_out | output | 1 | Negative flag candidate |
| v_out | output | 1 | Overflow flag candidate |
| s_out | output | 1 | Sign flag candidate |
| t_out | output | 1 | T flag candidate |
| flag_we | output | 6 | Write-enables {Z,C,N,V,S,T} |

## Verification
The only state in the unit is one output register. If that register is corrupted, the damage appears one cycle later:

- a wrong result byte;
- a flag that disagrees with the result (for example, Z set on a non-zero byte, or V not equal to N xor C);
- a write-enable raised for an operation that must leave the flags alone.

Every vector is compared against its hand-derived result, flags and enables on the very next cycle. A stale or swapped register therefore shows up within one operation. A back-to-back run and a mid-stream reset then confirm that no value carries over between operations.

// File: rtl/bit_shift_unit.sv
module bit_shift_unit #(
  parameter int W  = 8,
  parameter int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    op_sel,
  input  logic [W-1:0]  operand,
  input  logic [IW-1:0] bit_idx,
  input  logic          c_in,
  input  logic          t_in,
  output logic [W-1:0]  result,
  output logic          z_out,
  output logic          c_out,
  output logic          n_out,
  output logic          v_out,
  output logic          s_out,
  output logic          t_out,
  output logic [5:0]    flag_we
);
  localparam int HALF = W / 2;
  localparam logic [3:0] OP_SHL  = 4'd1;
  localparam logic [3:0] OP_SHR  = 4'd2;
  localparam logic [3:0] OP_ROTL = 4'd3;
  localparam logic [3:0] OP_ROTR = 4'd4;
  localparam logic [3:0] OP_SAR  = 4'd5;
  localparam logic [3:0] OP_NIB  = 4'd6;
  localparam logic [3:0] OP_TST  = 4'd7;
  localparam logic [3:0] OP_TLD  = 4'd8;
  localparam logic [5:0] WE_SHIFT = 6'b111110;
  localparam logic [5:0] WE_T     = 6'b000001;

  logic [W-1:0] nres;
  logic         ncarry, shifting, nt;
  logic [5:0]   nwe;

  always_comb begin
    nres     = operand;
    ncarry   = 1'b0;
    shifting = 1'b0;
    nt       = 1'b0;
    nwe      = '0;
    unique case (op_sel)
      OP_SHL:  begin nres = {operand[W-2:0], 1'b0};     ncarry = operand[W-1]; shifting = 1'b1; end
      OP_SHR:  begin nres = {1'b0, operand[W-1:1]};     ncarry = operand[0];   shifting = 1'b1; end
      OP_ROTL: begin nres = {operand[W-2:0], c_in};     ncarry = operand[W-1]; shifting = 1'b1; end
      OP_ROTR: begin nres = {c_in, operand[W-1:1]};     ncarry = operand[0];   shifting = 1'b1; end
      OP_SAR:  begin nres = {operand[W-1], operand[W-1:1]}; ncarry = operand[0]; shifting = 1'b1; end
      OP_NIB:  nres = {operand[HALF-1:0], operand[W-1:HALF]};
      OP_TST:  begin nt = operand[bit_idx]; nwe = WE_T; end
      OP_TLD:  nres[bit_idx] = t_in;
      default: ;
    endcase
    if (shifting) nwe = WE_SHIFT;
  end

  wire nneg = shifting & nres[W-1];
  wire nov  = shifting & (nres[W-1] ^ ncarry);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result  <= '0;
      {z_out, c_out, n_out, v_out, s_out, t_out} <= '0;
      flag_we <= '0;
    end else begin
      result  <= nres;
      z_out   <= shifting & (nres == '0);
      c_out   <= ncarry;
      n_out   <= nneg;
      v_out   <= nov;
      s_out   <= nneg ^ nov;
      t_out   <= nt;
      flag_we <= nwe;
    end
  end

  a_r1_shl: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == OP_SHL |=> result == {$past(operand[W-2:0]), 1'b0} && c_out == $past(operand[W-1]));
  a_r2_shr: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == OP_SHR |=> result[W-1] == 1'b0 && c_out == $past(operand[0]));
  a_r4_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == OP_SAR |=> result[W-1] == $past(operand[W-1]));
  a_r5_zero: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we[5] |-> z_out == (result == '0));
  a_r5_neg: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we[3] |-> n_out == result[W-1]);
  a_r5_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we[2] |-> v_out == (n_out ^ c_out));
  a_r5_sign: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we[1] |-> s_out == (n_out ^ v_out));
  a_r6_swap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == OP_NIB |=> flag_we == '0 && result == {$past(operand[HALF-1:0]), $past(operand[W-1:HALF])});
  a_r7_tstore: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == OP_TST |=> flag_we == WE_T && t_out == $past(operand[bit_idx]) && result == $past(operand));
  a_r8_tload: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == OP_TLD |=> flag_we == '0 && result[$past(bit_idx)] == $past(t_in));
  a_r9_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'd0 || op_sel > OP_TLD) |=> flag_we == '0 && result == $past(operand));
  a_r10_idle_flags: assert property (@(posedge clk) disable iff (!rst_n)
    ({z_out, c_out, n_out, v_out, s_out, t_out} & ~flag_we) == '0);
endmodule

// File: tb/bit_shift_unit_test.sv
module bit_shift_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 19;
  // {op[36:33], operand[32:25], idx[24:22], c[21], t[20], res[19:12], flags{Z,C,N,V,S,T}[11:6], we[5:0]}
  localparam logic [36:0] VEC [0:NV-1] = '{
    {4'd1, 8'h81, 3'd0, 1'b0, 1'b0, 8'h02, 6'b010110, 6'b111110}, // R1 R5
    {4'd1, 8'h80, 3'd0, 1'b0, 1'b0, 8'h00, 6'b110110, 6'b111110}, // R1 R5 zero
    {4'd1, 8'h40, 3'd0, 1'b1, 1'b0, 8'h80, 6'b001100, 6'b111110}, // R1 R5
    {4'd2, 8'h01, 3'd0, 1'b0, 1'b0, 8'h00, 6'b110110, 6'b111110}, // R2
    {4'd2, 8'h82, 3'd0, 1'b1, 1'b0, 8'h41, 6'b000000, 6'b111110}, // R2
    {4'd3, 8'h80, 3'd0, 1'b1, 1'b0, 8'h01, 6'b010110, 6'b111110}, // R3
    {4'd3, 8'h55, 3'd0, 1'b0, 1'b0, 8'hAA, 6'b001100, 6'b111110}, // R3
    {4'd4, 8'h01, 3'd0, 1'b1, 1'b0, 8'h80, 6'b011010, 6'b111110}, // R3
    {4'd4, 8'h00, 3'd0, 1'b0, 1'b1, 8'h00, 6'b100000, 6'b111110}, // R3 R5
    {4'd5, 8'h81, 3'd0, 1'b0, 1'b0, 8'hC0, 6'b011010, 6'b111110}, // R4
    {4'd5, 8'h7F, 3'd0, 1'b0, 1'b0, 8'h3F, 6'b010110, 6'b111110}, // R4
    {4'd6, 8'hA5, 3'd0, 1'b1, 1'b1, 8'h5A, 6'b000000, 6'b000000}, // R6
    {4'd7, 8'h10, 3'd4, 1'b0, 1'b0, 8'h10, 6'b000001, 6'b000001}, // R7
    {4'd7, 8'hEF, 3'd4, 1'b1, 1'b1, 8'hEF, 6'b000000, 6'b000001}, // R7
    {4'd8, 8'h00, 3'd7, 1'b0, 1'b1, 8'h80, 6'b000000, 6'b000000}, // R8
    {4'd8, 8'hFF, 3'd0, 1'b1, 1'b0, 8'hFE, 6'b000000, 6'b000000}, // R8
    {4'd0, 8'h3C, 3'd2, 1'b1, 1'b1, 8'h3C, 6'b000000, 6'b000000}, // R9
    {4'd15,8'hC3, 3'd5, 1'b1, 1'b1, 8'hC3, 6'b000000, 6'b000000}, // R9
    {4'd9, 8'h77, 3'd1, 1'b0, 1'b1, 8'h77, 6'b000000, 6'b000000}  // R9
  };

  logic clk = 0, rst_n = 0;
  logic [3:0] op_sel = 0;
  logic [7:0] operand = 0;
  logic [2:0] bit_idx = 0;
  logic c_in = 0, t_in = 0;
  logic [7:0] result;
  logic z_out, c_out, n_out, v_out, s_out, t_out;
  logic [5:0] flag_we;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bit_shift_unit uut (.clk(clk), .rst_n(rst_n), .op_sel(op_sel), .operand(operand),
    .bit_idx(bit_idx), .c_in(c_in), .t_in(t_in), .result(result), .z_out(z_out),
    .c_out(c_out), .n_out(n_out), .v_out(v_out), .s_out(s_out), .t_out(t_out), .flag_we(flag_we));

  task automatic check(input string tag, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [36:0] v);
    op_sel = v[36:33]; operand = v[32:25]; bit_idx = v[24:22]; c_in = v[21]; t_in = v[20];
  endtask

  wire [5:0] flags = {z_out, c_out, n_out, v_out, s_out, t_out};

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        check("R11 reset outputs", {result, flags, flag_we}, 20'h0);
        rst_n = 1;
        for (int i = 0; i < NV; i++) begin
          drive(VEC[i]);
          @(negedge clk);
          check($sformatf("R1-R9 vec%0d result", i), {12'h0, result}, {12'h0, VEC[i][19:12]});
          check($sformatf("R5/R10 vec%0d flags", i), {14'h0, flags}, {14'h0, VEC[i][11:6]});
          check($sformatf("R5 vec%0d enables", i), {14'h0, flag_we}, {14'h0, VEC[i][5:0]});
        end
        // R11 back-to-back: each cycle shows the previous cycle's operation
        drive(VEC[6]);
        @(negedge clk);
        drive(VEC[11]);
        check("R11 b2b first", {12'h0, result}, {12'h0, 8'hAA});
        @(negedge clk);
        check("R11 b2b second", {14'h0, flag_we}, 20'h0);
        check("R11 b2b second res", {12'h0, result}, {12'h0, 8'h5A});
        // R11 reset mid-stream clears outputs
        drive(VEC[0]);
        rst_n = 0;
        @(negedge clk);
        check("R11 mid reset", {result, flags, flag_we}, 20'h0);
        rst_n = 1;
        // R10 quiet flags after a flag-writing op
        drive(VEC[17]);
        @(negedge clk);
        check("R10 flags low when disabled", {14'h0, flags}, 20'h0);
      end
      begin
        repeat (2000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule